// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM Port Front End

This block models the port logic of a separate-I/O, quad-data-rate static RAM that moves four-beat bursts. One shared address bus serves two independent ports. An active-low read select and an active-low write select are sampled only on the rising edge of the K clock. Write data and active-low per-lane write enables are taken on every beat. Read data comes back on every beat after a fixed two-K-cycle latency. A valid flag and an output-enable indication run alongside the read data. The storage array is small and parameterized.

The model runs on one internal clock at twice the K rate, so each internal cycle carries one beat. A phase register marks which internal edge stands for the rising edge of K (phase 0) and which stands for the rising edge of K# (phase 1). The `k_edge` output tells the surrounding logic when the coming edge is a K edge. A burst at base address A touches the words {A, 0} through {A, 3} in that order, where the beat index forms the two low bits of the word address.

Top module: `qdr_sram_fe`

## Requirements
- R1: After reset, `k_edge` is 1 and then alternates on every clock. A read or write select asserted on an edge where `k_edge` is 0 starts nothing: no read data appears and no word changes.
- R2: A write accepted on a K edge stores `d` at word {addr, 0} on that same edge. It stores the next three beats of `d` at words {addr, 1}, {addr, 2} and {addr, 3} on the three edges that follow.
- R3: On each write beat, lane i covers bits 9i+8 down to 9i. Lane i is written only when `bw_n[i]` is 0. When `bw_n[i]` is 1, that lane of the word keeps its previous value.
- R4: While `wr_n` is 1, the values on `addr`, `d` and `bw_n` change no stored word.
- R5: For a read accepted on edge t, word {addr, 0} appears on `q` after edge t+4, which is two K cycles later. Words 1, 2 and 3 follow after edges t+5, t+6 and t+7.
- R6: `q_valid` and `q_oe` are 1 exactly while burst data is on `q`. Whenever they are 0, `q` is all zeros.
- R7: A select of either port on the K edge two clocks after that port accepted a burst is ignored: it starts no second burst and writes nothing.
- R8: Once a read has been accepted and `rd_n` is released, all four beats are still delivered. After the edge that ends the burst, `q_valid` and `q_oe` are 0.
- R9: Reads accepted on K edges four clocks apart give eight back-to-back valid beats with no gap.
- R10: When a read and a write hit the same base address on the same K edge, the read returns the words as they were before that write.
- R11: While reset is held and after it is released, `q_valid`, `q_oe` and `q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the K rate; one beat per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Active-low read select, sampled on K edges |
| wr_n | input | 1 | Active-low write select, sampled on K edges |
| addr | input | ADDR_W | Shared burst base address |
| d | input | LANES*LANE_W | Write data, one beat per cycle |
| bw_n | input | LANES | Active-low lane write enables, one bit per 9-bit lane |
| q | output | LANES*LANE_W | Read data, zero when not valid |
| q_valid | output | 1 | High while read data is on `q` |
| q_oe | output | 1 | Output-driver enable indication; low means the bus would float |
| k_edge | output | 1 | High when the next clock edge stands for the rising edge of K |

## Verification
The bound checker watches the timing skeleton on every cycle. It checks that the phase alternates, that an accepted read is followed by valid data exactly five edges later, and that every valid run on `q` starts from an accepted read. It also checks that each run is a whole number of four-beat bursts, that `q` stays zero while not valid, and that neither port accepts a second burst during its first one. Data content is shown only by the bench's scenarios, which write and read back known words. These scenarios cover lane-masked merges, writes with the port deselected, selects on K# edges, selects arriving mid-burst, back-to-back reads, and a read and a write colliding on the same base address.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    localparam int BURST_LEN    = 4;
    localparam int BEAT_W       = $clog2(BURST_LEN);
    localparam int RD_LAT_K     = 2;
    localparam int RD_LAT_BEATS = 2 * RD_LAT_K;
    localparam int RD_PIPE_D    = RD_LAT_BEATS + 1;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        PH_RISE_K  = 1'b0,
        PH_RISE_KN = 1'b1
    } phase_e;

    typedef struct packed {
        logic  active;
        beat_t beat;
    } burst_st_t;

    function automatic beat_t beat_succ(input beat_t b);
        return b + beat_t'(1);
    endfunction

    function automatic logic beat_is_last(input beat_t b);
        return b == beat_t'(BURST_LEN - 1);
    endfunction

    function automatic phase_e phase_flip(input phase_e p);
        return (p == PH_RISE_K) ? PH_RISE_KN : PH_RISE_K;
    endfunction

endpackage

// File: rtl/qdr_port_seq.sv
module qdr_port_seq
    import qdr_pkg::*;
#(
    parameter  int ADDR_W  = 4,
    localparam int WADDR_W = ADDR_W + BEAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               k_edge,
    input  logic               sel_n,
    input  logic [ADDR_W-1:0]  addr,
    output logic               acc,
    output logic               live,
    output logic [WADDR_W-1:0] word_addr
);

    burst_st_t         st;
    logic [ADDR_W-1:0] base;

    // a new burst starts only on a K edge while this port is idle
    assign acc       = k_edge && !sel_n && !st.active;
    assign live      = acc || st.active;
    assign word_addr = acc ? {addr, beat_t'(0)} : {base, st.beat};

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            base <= '0;
        end else if (acc) begin
            st.active <= 1'b1;
            st.beat   <= beat_t'(1);
            base      <= addr;
        end else if (st.active) begin
            if (beat_is_last(st.beat)) begin
                st.active <= 1'b0;
            end
            st.beat <= beat_succ(st.beat);
        end
    end

endmodule

// File: rtl/qdr_array.sv
module qdr_array #(
    parameter  int WADDR_W = 6,
    parameter  int LANES   = 4,
    parameter  int LANE_W  = 9,
    localparam int DATA_W  = LANES * LANE_W,
    localparam int DEPTH   = 1 << WADDR_W
) (
    input  logic               clk,
    input  logic               we,
    input  logic [WADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [LANES-1:0]   wmask_n,
    input  logic [WADDR_W-1:0] raddr,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // read sees contents before any write on the same edge
    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (!wmask_n[l]) begin
                    mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
                end
            end
        end
    end

endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe #(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_live,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) begin
                pipe[s] <= '0;
            end
        end else begin
            pipe[0].valid <= in_live;
            pipe[0].data  <= in_live ? in_data : '0;
            for (int s = 1; s < DEPTH; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign out_valid = pipe[DEPTH-1].valid;
    assign out_data  = pipe[DEPTH-1].data;

endmodule

// File: rtl/qdr_sram_fe.sv
module qdr_sram_fe
    import qdr_pkg::*;
#(
    parameter  int ADDR_W = 4,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] d,
    input  logic [LANES-1:0]  bw_n,
    output logic [DATA_W-1:0] q,
    output logic              q_valid,
    output logic              q_oe,
    output logic              k_edge
);

    localparam int WADDR_W = ADDR_W + BEAT_W;

    phase_e             ph;
    logic               wr_acc, wr_live, rd_acc, rd_live;
    logic [WADDR_W-1:0] wr_wa, rd_wa;
    logic [DATA_W-1:0]  arr_q;

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_RISE_K;
        else     ph <= phase_flip(ph);
    end

    assign k_edge = (ph == PH_RISE_K);

    qdr_port_seq #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst), .k_edge(k_edge), .sel_n(wr_n), .addr(addr),
        .acc(wr_acc), .live(wr_live), .word_addr(wr_wa)
    );

    qdr_port_seq #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst), .k_edge(k_edge), .sel_n(rd_n), .addr(addr),
        .acc(rd_acc), .live(rd_live), .word_addr(rd_wa)
    );

    qdr_array #(.WADDR_W(WADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .we(wr_live), .waddr(wr_wa), .wdata(d), .wmask_n(bw_n),
        .raddr(rd_wa), .rdata(arr_q)
    );

    qdr_rd_pipe #(.DATA_W(DATA_W), .DEPTH(RD_PIPE_D)) u_pipe (
        .clk(clk), .rst(rst), .in_live(rd_live), .in_data(arr_q),
        .out_valid(q_valid), .out_data(q)
    );

    assign q_oe = q_valid;

endmodule

// File: rtl/qdr_sram_chk.sv
module qdr_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              k_edge,
    input logic              rd_acc,
    input logic              wr_acc,
    input logic              q_valid,
    input logic              q_oe,
    input logic [DATA_W-1:0] q
);

    localparam int LAT = qdr_pkg::RD_PIPE_D;

    logic [1:0] run;

    always_ff @(posedge clk) begin
        if (rst)          run <= '0;
        else if (q_valid) run <= run + 2'd1;
        else              run <= '0;
    end

    AST_K_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (k_edge != $past(k_edge)));                 // R1

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_acc |-> ##LAT (q_valid && q_oe));                         // R5

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(q_valid) |-> $past(rd_acc, LAT));                      // R6

    AST_Q_QUIET: assert property (@(posedge clk) disable iff (rst)
        !q_valid |-> (q == '0 && !q_oe));                            // R6

    AST_BURST_WHOLE: assert property (@(posedge clk) disable iff (rst)
        $fell(q_valid) |-> (run == 2'd0));                           // R8

    AST_WR_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
        wr_acc |-> ##2 !wr_acc);                                     // R7

    AST_RD_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
        rd_acc |-> ##2 !rd_acc);                                     // R7

endmodule

bind qdr_sram_fe qdr_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .k_edge(k_edge), .rd_acc(rd_acc), .wr_acc(wr_acc),
    .q_valid(q_valid), .q_oe(q_oe), .q(q)
);

// File: tb/sim_qdr_sram_fe.sv
module sim_qdr_sram_fe;

    localparam int AW = 4;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int W  = LN * LW;

    typedef logic [W-1:0] burst_t [4];

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  d = '0;
    logic [LN-1:0] bw_n = '1;
    logic [W-1:0]  q;
    logic          q_valid, q_oe, k_edge;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [W-1:0] model [64];

    qdr_sram_fe #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .d(d),
        .bw_n(bw_n), .q(q), .q_valid(q_valid), .q_oe(q_oe), .k_edge(k_edge)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] merge(input logic [W-1:0] o, input logic [W-1:0] n,
                                           input logic [LN-1:0] m);
        for (int l = 0; l < LN; l++) begin
            if (!m[l]) o[l*LW +: LW] = n[l*LW +: LW];
        end
        return o;
    endfunction

    function automatic burst_t mk(input int seed);
        burst_t x;
        for (int b = 0; b < 4; b++) begin
            x[b] = {9'(seed * 7 + b), 9'(seed + 3 * b + 1), 9'(seed * 13 + b + 5), 9'(seed + b * 11 + 2)};
        end
        return x;
    endfunction

    task automatic idle();
        rd_n = 1'b1; wr_n = 1'b1; addr = '0; d = '0; bw_n = '1;
    endtask

    task automatic align();
        @(negedge clk);
        while (!k_edge) @(negedge clk);
    endtask

    task automatic wr_burst(input int a, input burst_t dat, input logic [15:0] masks);
        align();
        for (int b = 0; b < 4; b++) begin
            wr_n = (b != 0);
            addr = (b == 0) ? AW'(a) : '0;
            d    = dat[b];
            bw_n = masks[b*4 +: 4];
            model[a*4+b] = merge(model[a*4+b], dat[b], masks[b*4 +: 4]);
            @(negedge clk);
        end
        idle();
    endtask

    task automatic rd_burst(input int a, input string tag);
        burst_t e;
        align();
        for (int b = 0; b < 4; b++) e[b] = model[a*4+b];
        rd_n = 1'b0; addr = AW'(a);
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        chk(W'(q_valid), 0, {tag, " R5 no early data"});
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            chk(q, e[b], $sformatf("%s R5 beat %0d", tag, b));
            chk(W'(q_valid), 1, {tag, " R6 valid"});
            chk(W'(q_oe), 1, {tag, " R6 oe"});
        end
        @(negedge clk);
        chk(W'(q_valid), 0, {tag, " R8 valid off"});
        chk(W'(q_oe), 0, {tag, " R8 oe off"});
        chk(q, 0, {tag, " R6 q quiet"});
    endtask

    task automatic t_reset();
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(W'(q_valid), 0, "R11 valid in reset");
        rst = 1'b0;
        chk(W'(q_valid), 0, "R11 valid after reset");
        chk(W'(q_oe), 0, "R11 oe after reset");
        chk(q, 0, "R11 q after reset");
        chk(W'(k_edge), 1, "R1 first edge is K");
    endtask

    task automatic t_basic();
        wr_burst(3, mk(3), 16'h0000);
        rd_burst(3, "R2 addr3");
        wr_burst(9, mk(9), 16'h0000);
        rd_burst(9, "R2 addr9");
        rd_burst(3, "R2 addr3 again");
    endtask

    task automatic t_lanes();
        // beat masks: 1110, 0101, 1111, 0000 (bit=0 writes that lane)
        wr_burst(3, mk(21), {4'b0000, 4'b1111, 4'b0101, 4'b1110});
        rd_burst(3, "R3 lane merge");
    endtask

    task automatic t_desel();
        align();
        for (int b = 0; b < 4; b++) begin
            wr_n = 1'b1; addr = AW'(3); d = {W{1'b1}}; bw_n = '0;
            @(negedge clk);
        end
        idle();
        rd_burst(3, "R4 deselected write");
    endtask

    task automatic t_kphase();
        align();
        @(negedge clk);
        chk(W'(k_edge), 0, "R1 phase alternates");
        rd_n = 1'b0; wr_n = 1'b0; addr = AW'(3); d = {W{1'b1}}; bw_n = '0;
        @(negedge clk);
        idle();
        for (int n = 0; n < 8; n++) begin
            chk(W'(q_valid), 0, "R1 no read from K# select");
            @(negedge clk);
        end
        rd_burst(3, "R1 no write from K# select");
    endtask

    task automatic t_midburst();
        burst_t x;
        wr_burst(6, mk(6), 16'h0000);
        x = mk(5);
        align();
        for (int b = 0; b < 4; b++) begin
            wr_n = !(b == 0 || b == 2);
            addr = (b == 0) ? AW'(5) : (b == 2) ? AW'(6) : '0;
            d    = x[b];
            bw_n = '0;
            model[5*4+b] = x[b];
            @(negedge clk);
        end
        idle();
        rd_burst(5, "R7 first write burst");
        rd_burst(6, "R7 mid-burst write ignored");
        align();
        rd_n = 1'b0; addr = AW'(5);
        @(negedge clk);
        idle();
        @(negedge clk);
        rd_n = 1'b0; addr = AW'(6);
        @(negedge clk);
        idle();
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            chk(q, model[5*4+b], $sformatf("R7 read beat %0d", b));
        end
        @(negedge clk);
        chk(W'(q_valid), 0, "R7 mid-burst read ignored");
    endtask

    task automatic t_b2b();
        align();
        rd_n = 1'b0; addr = AW'(3);
        for (int n = 1; n <= 13; n++) begin
            @(negedge clk);
            if (n == 4) begin
                rd_n = 1'b0; addr = AW'(5);
            end else begin
                idle();
            end
            if (n >= 5 && n <= 8) begin
                chk(q, model[3*4+n-5], $sformatf("R9 first burst beat %0d", n - 5));
                chk(W'(q_valid), 1, "R9 valid first");
            end else if (n >= 9 && n <= 12) begin
                chk(q, model[5*4+n-9], $sformatf("R9 second burst beat %0d", n - 9));
                chk(W'(q_valid), 1, "R9 valid continuous");
            end else if (n == 13) begin
                chk(W'(q_valid), 0, "R9 valid ends");
            end
        end
    endtask

    task automatic t_rbw();
        burst_t old;
        burst_t nw;
        wr_burst(7, mk(7), 16'h0000);
        for (int b = 0; b < 4; b++) old[b] = model[7*4+b];
        nw = mk(40);
        align();
        for (int b = 0; b < 4; b++) begin
            rd_n = (b != 0); wr_n = (b != 0);
            addr = (b == 0) ? AW'(7) : '0;
            d = nw[b]; bw_n = '0;
            model[7*4+b] = nw[b];
            @(negedge clk);
        end
        idle();
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            chk(q, old[b], $sformatf("R10 old data beat %0d", b));
        end
        rd_burst(7, "R10 new data later");
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_lanes();
        t_desel();
        t_kphase();
        t_midburst();
        t_b2b();
        t_rbw();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule